// File: doc/BRIEF.md
# Sticky-Preserving Significand Alignment Shifter

This block prepares the smaller operand of a floating-point magnitude subtraction. It takes the signed exponents of both operands and their 64-bit normalized significands. It subtracts the small exponent from the large one and uses the result as a right-shift distance. It then shifts the small operand's significand right by that distance. The result is a 64-bit aligned significand plus a 32-bit extension word. The extension word keeps guard bits and, when needed, a sticky bit, so a later subtract-and-round stage still sees that bits were discarded.

Shifts below 32 move bits straight into the extension word. Longer shifts fold the discarded low material into extension bit 0, with dedicated handling at exactly 32, exactly 64, exactly 65, and beyond 65. The block also checks its preconditions. If the exponent difference is negative, or if either significand lacks its leading one, the block raises an internal-error flag.

Operands arrive through a valid/ready handshake. Each result is registered and appears one cycle after its input is accepted.

Top module: `sig_align_shift`

## Requirements
- R1: The shift distance is the signed 16-bit `exp_big` minus the signed 16-bit `exp_small`, evaluated without overflow. A negative distance sets `out_err`. Distances above 65 give the same result as 66.
- R2: For a distance n of 0 to 31, {`out_sig`,`out_ext`} equals the 96-bit value {`sig_small`, 32 zero bits} shifted right by n.
- R3: For a distance of exactly 32, `out_sig` is {32 zeros, upper word of `sig_small`} and `out_ext` is the lower word of `sig_small`.
- R4: For a distance n of 33 to 63, `out_sig[31:0]` is the upper word shifted right by n-32, and `out_sig[63:32]` is zero. `out_ext` holds the bits of the upper word that were shifted out, left-aligned, and its bit 0 is ORed with "lower word nonzero".
- R5: For a distance of exactly 64, `out_sig` is zero. `out_ext` is the upper word with bit 0 ORed with "lower word nonzero".
- R6: For a distance of exactly 65, `out_sig` is zero. `out_ext` is the upper word shifted right by one, with bit 0 ORed with the bit shifted out and with "lower word nonzero".
- R7: For a distance above 65, `out_sig` is zero and `out_ext` is exactly 1.
- R8: If bit 63 of `sig_big` or of `sig_small` is clear, `out_err` is set. Whenever `out_err` is set, `out_sig` and `out_ext` are zero.
- R9: `in_ready` is high when no result is held or the held result is being taken. An accepted input gives `out_valid` on the next cycle. A result that is not taken stays unchanged.
- R10: `out_exp` is the `exp_big` of the accepted operation. After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present |
| in_ready | output | 1 | Block can accept operands |
| exp_big | input | 16 | Signed exponent of the larger operand |
| exp_small | input | 16 | Signed exponent of the smaller operand |
| sig_big | input | 64 | Significand of the larger operand (normalization check only) |
| sig_small | input | 64 | Significand to be aligned |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sig | output | 64 | Aligned significand |
| out_ext | output | 32 | Extension word: guard bits and sticky |
| out_exp | output | 16 | Result exponent (copy of exp_big) |
| out_err | output | 1 | Internal error: negative distance or unnormalized input |

## Verification
The bench aims at the distances where the rule changes: 31, 32, 33 to 63, 64, 65 and 66. It runs each one with and without a nonzero lower word, and at 65 with the upper word's bit 0 set. A design that dropped the sticky OR would return an extension with bit 0 clear and so make a nonzero operand look exact. A design that treated 65 like 64 would return the unshifted upper word.

The extreme exponent pair 32767 and -32768 exposes any 16-bit wrap in the difference, which would appear either as an error or as a short shift. The bench also checks negative distances, unnormalized operands and a stalled consumer. A faulty error gate would let data through, and a broken hold would change a result that has not been taken.

// File: rtl/sig_align_shift.sv
module sig_align_shift #(
  parameter int EXP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [EXP_W-1:0] exp_big,
  input  logic [EXP_W-1:0] exp_small,
  input  logic [63:0]      sig_big,
  input  logic [63:0]      sig_small,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [63:0]      out_sig,
  output logic [31:0]      out_ext,
  output logic [EXP_W-1:0] out_exp,
  output logic             out_err
);
  localparam int W    = 32;
  localparam int SW   = 2 * W;
  localparam int SH_W = 7;
  localparam logic [SH_W-1:0]  D_W    = SH_W'(W);
  localparam logic [SH_W-1:0]  D_SW   = SH_W'(SW);
  localparam logic [SH_W-1:0]  D_SW1  = SH_W'(SW + 1);
  localparam logic [SH_W-1:0]  D_SAT  = SH_W'(SW + 2);
  localparam logic [EXP_W-1:0] E_SAT  = EXP_W'(SW + 2);

  logic signed [EXP_W:0] diff;
  logic                  neg, err_n, lo_nz;
  logic [SH_W-1:0]       amt, off;
  logic [W-1:0]          hi, lo, ext_n;
  logic [SW-1:0]         sig_n, hlane;
  logic [SW+W-1:0]       lane;

  assign diff  = $signed({exp_big[EXP_W-1], exp_big}) - $signed({exp_small[EXP_W-1], exp_small});
  assign neg   = diff[EXP_W];
  assign amt   = neg ? '0 : (diff[EXP_W-1:0] > E_SAT) ? D_SAT : diff[SH_W-1:0];
  assign err_n = neg | ~sig_big[SW-1] | ~sig_small[SW-1];
  assign hi    = sig_small[SW-1:W];
  assign lo    = sig_small[W-1:0];
  assign lo_nz = |lo;
  assign off   = amt - D_W;
  assign lane  = {sig_small, {W{1'b0}}} >> amt;
  assign hlane = {hi, {W{1'b0}}} >> off;

  always_comb begin
    sig_n = '0;
    ext_n = '0;
    if (err_n) begin
      sig_n = '0;
      ext_n = '0;
    end else if (amt < D_W) begin
      {sig_n, ext_n} = lane;
    end else if (amt == D_W) begin
      sig_n = {{W{1'b0}}, hi};
      ext_n = lo;
    end else if (amt < D_SW) begin
      sig_n = {{W{1'b0}}, hlane[SW-1:W]};
      ext_n = hlane[W-1:0] | {{(W-1){1'b0}}, lo_nz};
    end else if (amt == D_SW) begin
      ext_n = hi | {{(W-1){1'b0}}, lo_nz};
    end else if (amt == D_SW1) begin
      ext_n = {1'b0, hi[W-1:1]} | {{(W-1){1'b0}}, hi[0] | lo_nz};
    end else begin
      ext_n = {{(W-1){1'b0}}, 1'b1};
    end
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sig   <= '0;
      out_ext   <= '0;
      out_exp   <= '0;
      out_err   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sig <= sig_n;
        out_ext <= ext_n;
        out_exp <= exp_big;
        out_err <= err_n;
      end
    end
  end
endmodule

module sig_align_shift_chk #(
  parameter int EXP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [EXP_W-1:0] exp_big,
  input logic [63:0]      sig_small,
  input logic             out_valid,
  input logic             out_ready,
  input logic [63:0]      out_sig,
  input logic [31:0]      out_ext,
  input logic [EXP_W-1:0] out_exp,
  input logic             out_err
);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sig) && $stable(out_ext) && $stable(out_err));
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r10_exp: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_exp == $past(exp_big));
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_sig == 64'd0 && out_ext == 32'd0);
  a_r7_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err && out_sig == 64'd0 |-> out_ext != 32'd0);
  a_r2_no_shift_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err && out_sig[63] |-> out_ext == 32'd0);
endmodule

bind sig_align_shift sig_align_shift_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .exp_big(exp_big), .sig_small(sig_small), .out_valid(out_valid),
  .out_ready(out_ready), .out_sig(out_sig), .out_ext(out_ext),
  .out_exp(out_exp), .out_err(out_err)
);

// File: tb/sim_sig_align_shift.sv
module sim_sig_align_shift;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, out_err;
  logic [15:0] exp_big = '0, exp_small = '0, out_exp;
  logic [63:0] sig_big = 64'h8000_0000_0000_0000, sig_small = '0, out_sig;
  logic [31:0] out_ext;
  int          errors = 0, checks = 0;
  bit          done = 0;

  localparam logic [63:0] A = 64'h8123_4567_89AB_CDEF;
  localparam logic [63:0] N = 64'h8000_0000_0000_0000;

  always #2 clk = ~clk;

  sig_align_shift u0 (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input string tag, input logic [15:0] eb, input logic [15:0] es,
                    input logic [63:0] sb, input logic [63:0] ss,
                    input logic [63:0] e_sig, input logic [31:0] e_ext, input logic e_err);
    @(negedge clk);
    exp_big = eb; exp_small = es; sig_big = sb; sig_small = ss; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, 128'(out_valid), 128'd1);
    chk({tag, " sig"}, 128'(out_sig), 128'(e_sig));
    chk({tag, " ext"}, 128'(out_ext), 128'(e_ext));
    chk({tag, " err"}, 128'(out_err), 128'(e_err));
  endtask

  task automatic t_reset();
    chk("R10 reset out_valid", 128'(out_valid), 128'd0);
    chk("R9 reset in_ready", 128'(in_ready), 128'd1);
  endtask

  task automatic t_short();
    logic [95:0] r;
    op("R2 shift0", 16'd100, 16'd100, N, A, A, 32'h0, 1'b0);
    op("R2 shift4", 16'd104, 16'd100, N, A, 64'h0812_3456_789A_BCDE, 32'hF000_0000, 1'b0);
    r = {A, 32'h0} >> 31;
    op("R2 shift31", 16'd31, 16'd0, N, A, r[95:32], r[31:0], 1'b0);
    chk("R10 out_exp", 128'(out_exp), 128'd31);
  endtask

  task automatic t_word();
    op("R3 shift32", 16'd10, -16'sd22, N, A, 64'h0000_0000_8123_4567, 32'h89AB_CDEF, 1'b0);
    op("R4 shift36 sticky", 16'd36, 16'd0, N, A, 64'h0812_3456, 32'h7000_0001, 1'b0);
    op("R4 shift36 clean", 16'd36, 16'd0, N, 64'h8123_4567_0000_0000, 64'h0812_3456, 32'h7000_0000, 1'b0);
    op("R4 shift63", 16'd63, 16'd0, N, A, 64'h1, 32'h0246_8ACF, 1'b0);
  endtask

  task automatic t_long();
    op("R5 shift64 sticky", 16'd64, 16'd0, N, 64'h8000_0000_0000_0001, 64'h0, 32'h8000_0001, 1'b0);
    op("R5 shift64 clean", 16'd64, 16'd0, N, N, 64'h0, 32'h8000_0000, 1'b0);
    op("R6 shift65 clean", 16'd65, 16'd0, N, N, 64'h0, 32'h4000_0000, 1'b0);
    op("R6 shift65 outbit", 16'd65, 16'd0, N, 64'h8000_0001_0000_0000, 64'h0, 32'h4000_0001, 1'b0);
    op("R6 shift65 lowword", 16'd65, 16'd0, N, 64'h8000_0000_0000_0002, 64'h0, 32'h4000_0001, 1'b0);
    op("R7 shift66", 16'd66, 16'd0, N, A, 64'h0, 32'h1, 1'b0);
    op("R1 R7 extreme", 16'h7FFF, 16'h8000, N, A, 64'h0, 32'h1, 1'b0);
    chk("R10 out_exp extreme", 128'(out_exp), 128'h7FFF);
  endtask

  task automatic t_err();
    op("R1 negative", 16'd5, 16'd6, N, A, 64'h0, 32'h0, 1'b1);
    op("R8 small unnorm", 16'd8, 16'd0, N, 64'h4000_0000_0000_0000, 64'h0, 32'h0, 1'b1);
    op("R8 big unnorm", 16'd8, 16'd0, 64'h7FFF_FFFF_FFFF_FFFF, A, 64'h0, 32'h0, 1'b1);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    exp_big = 16'd32; exp_small = 16'd0; sig_big = N; sig_small = A; in_valid = 1'b1;
    @(negedge clk);
    exp_big = 16'd66; sig_small = N;
    chk("R9 stall in_ready", 128'(in_ready), 128'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 stall valid", 128'(out_valid), 128'd1);
    chk("R9 stall held sig", 128'(out_sig), 128'h0000_0000_8123_4567);
    chk("R9 stall held ext", 128'(out_ext), 128'h89AB_CDEF);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 drain next sig", 128'(out_sig), 128'h0);
    chk("R9 drain next ext", 128'(out_ext), 128'h1);
    @(negedge clk);
    chk("R9 drained empty", 128'(out_valid), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_short();
    t_word();
    t_long();
    t_err();
    t_stall();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule